// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Transceiver

This block is a full-duplex character link with two independent halves. One half serializes parallel bytes onto an outgoing line. The other half recovers bytes from an incoming line. A shared baud tick runs at sixteen times the bit rate. The bit period is set by a divider value applied at an input, so the same block serves any rate the system clock can reach.

A transmitted character has the following parts, in this order:
- a low start bit;
- eight data bits, least significant first;
- an optional parity bit;
- a high stop period of one, one and a half, or two bit times.

The receiver works as follows:
- It brings the incoming line into the clock domain and watches for the high-to-low edge.
- It confirms the start bit half a cell later.
- It samples every following bit at its centre.
- It reports the byte with a single-cycle strobe, together with a parity error flag and a framing error flag.

Level shifting and line inversion are handled outside the block.

Top module: `serial_xcvr`

## Requirements
- R1: After reset `txd` is 1, `tx_busy` is 0 and `rx_valid` is 0. `txd` is 1 in every cycle in which `tx_busy` is 0.
- R2: The oversample tick repeats every `baud_div` clock cycles. A `baud_div` of 0 behaves as 1. One bit cell lasts 16 ticks.
- R3: A request (`tx_valid`=1) seen while `tx_busy`=0 is accepted. In the next cycle `tx_busy` is 1 and `txd` is 0, which is the start bit. Eight data bits follow, least significant bit first, and then the stop period at 1. A request seen while `tx_busy`=1 is ignored.
- R4: With `par_en`=1, one parity bit follows the data. With `par_odd`=0 the count of ones in data plus parity is even. With `par_odd`=1 that count is odd. With `par_en`=0 there is no parity bit.
- R5: The stop period is set by `stop_sel`: 0 gives 16 ticks, 1 gives 24 ticks, and 2 or 3 give 32 ticks. `tx_busy` stays 1 from acceptance until the last stop tick has elapsed. The frame therefore lasts 16·(9+`par_en`) ticks plus the stop ticks.
- R6: `rxd` passes through a two-flop synchronizer before falling-edge detection. At tick 8 after the edge the line is checked again. If it is 1, the event is dropped as a false start and no `rx_valid` follows.
- R7: Each data bit is sampled 16 ticks after the previous sample point, least significant bit first. The byte appears on `rx_data` with a one-cycle `rx_valid` pulse. `rx_data` and both flags hold their value until the next pulse.
- R8: `rx_parity_err` is 1 when `par_en`=1 and the received parity bit breaks the rule of R4. It is always 0 when `par_en`=0.
- R9: `rx_frame_err` is 1 when the first stop bit is sampled as 0.
- R10: The receiver accepts frames back to back with no idle gap between a stop period and the next start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_div | input | DIV_W | Clock cycles per oversample tick |
| par_en | input | 1 | Enables the parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| stop_sel | input | 2 | Stop length code: 0 = 1, 1 = 1.5, 2 or 3 = 2 bit times |
| tx_valid | input | 1 | Request to send `tx_data` |
| tx_data | input | DATA_W | Byte to send |
| tx_busy | output | 1 | Transmitter occupied by a frame |
| txd | output | 1 | Outgoing serial line |
| rxd | input | 1 | Incoming serial line (asynchronous) |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | DATA_W | Received byte |
| rx_frame_err | output | 1 | Stop bit of the last byte was low |
| rx_parity_err | output | 1 | Parity of the last byte was wrong |

## Verification
The transmitted line is decoded at cell centres, and the busy length is measured for each stop code. A 1.5-stop setting that rounds to 16 or 32 ticks shows up as a wrong busy length, and a parity sense that is inverted shows up in the decoded parity bit. A request made in the middle of a frame must neither restart the frame nor queue a second byte. If it did, the scoreboard would see an extra byte or corrupted data. On the receive side, the bench drives frames with a wrong parity bit and with a low stop bit, drives a glitch shorter than half a cell, and sends frames with no gap between them. A receiver that skipped the start recheck would deliver a phantom byte. One that waited for a full stop bit would miss the next start edge.

// File: rtl/serial_xcvr_pkg.sv
`timescale 1ns/1ps
package serial_xcvr_pkg;

   // stop length codes on stop_sel; codes 2 and 3 both give two bit times
   localparam logic [1:0] STOP_ONE      = 2'd0;
   localparam logic [1:0] STOP_ONE_HALF = 2'd1;
   localparam logic [1:0] STOP_TWO      = 2'd2;

   typedef enum logic [2:0] {
      TX_IDLE,
      TX_START,
      TX_DATA,
      TX_PAR,
      TX_STOP
   } tx_state_e;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP
   } rx_state_e;

endpackage

// File: rtl/serial_xcvr_baud.sv
`timescale 1ns/1ps
module serial_xcvr_baud #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] baud_div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] lim;

   // a divider of zero runs the tick every cycle
   assign lim = (baud_div == '0) ? '0 : baud_div - DIV_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (cnt >= lim) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + DIV_W'(1);
         tick <= 1'b0;
      end
   end

endmodule

// File: rtl/serial_xcvr_tx.sv
`timescale 1ns/1ps
module serial_xcvr_tx
   import serial_xcvr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic [1:0]        stop_sel,
   input  logic              tx_valid,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_busy,
   output logic              txd
);

   localparam int TW = $clog2(2*OVS) + 1;
   localparam int BW = $clog2(DATA_W + 1);
   localparam logic [TW-1:0] CELL_LAST  = TW'(OVS - 1);
   localparam logic [TW-1:0] STOP1_LAST = TW'(OVS - 1);
   localparam logic [TW-1:0] STOPH_LAST = TW'(OVS + OVS/2 - 1);
   localparam logic [TW-1:0] STOP2_LAST = TW'(2*OVS - 1);

   tx_state_e         st;
   logic [TW-1:0]     tcnt;
   logic [BW-1:0]     bidx;
   logic [DATA_W-1:0] shreg;
   logic              pbit;
   logic              pen_q;
   logic [1:0]        stop_q;
   logic [TW-1:0]     stop_last;
   logic [TW-1:0]     cur_last;
   logic              cell_end;

   always_comb begin
      case (stop_q)
         STOP_ONE:      stop_last = STOP1_LAST;
         STOP_ONE_HALF: stop_last = STOPH_LAST;
         default:       stop_last = STOP2_LAST;
      endcase
   end

   assign cur_last = (st == TX_STOP) ? stop_last : CELL_LAST;
   assign cell_end = tick && (tcnt == cur_last);
   assign tx_busy  = (st != TX_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= TX_IDLE;
         txd    <= 1'b1;
         tcnt   <= '0;
         bidx   <= '0;
         shreg  <= '0;
         pbit   <= 1'b0;
         pen_q  <= 1'b0;
         stop_q <= STOP_ONE;
      end else begin
         case (st)
            TX_IDLE: begin
               if (tx_valid) begin
                  shreg  <= tx_data;
                  pbit   <= (^tx_data) ^ par_odd;
                  pen_q  <= par_en;
                  stop_q <= stop_sel;
                  tcnt   <= '0;
                  bidx   <= '0;
                  txd    <= 1'b0;
                  st     <= TX_START;
               end
            end
            default: begin
               if (tick) begin
                  if (!cell_end) begin
                     tcnt <= tcnt + TW'(1);
                  end else begin
                     tcnt <= '0;
                     case (st)
                        TX_START: begin
                           txd   <= shreg[0];
                           shreg <= shreg >> 1;
                           bidx  <= BW'(1);
                           st    <= TX_DATA;
                        end
                        TX_DATA: begin
                           if (bidx == BW'(DATA_W)) begin
                              if (pen_q) begin
                                 txd <= pbit;
                                 st  <= TX_PAR;
                              end else begin
                                 txd <= 1'b1;
                                 st  <= TX_STOP;
                              end
                           end else begin
                              txd   <= shreg[0];
                              shreg <= shreg >> 1;
                              bidx  <= bidx + BW'(1);
                           end
                        end
                        TX_PAR: begin
                           txd <= 1'b1;
                           st  <= TX_STOP;
                        end
                        TX_STOP: begin
                           txd <= 1'b1;
                           st  <= TX_IDLE;
                        end
                        default: begin
                           txd <= 1'b1;
                           st  <= TX_IDLE;
                        end
                     endcase
                  end
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/serial_xcvr_rx.sv
`timescale 1ns/1ps
module serial_xcvr_rx
   import serial_xcvr_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16,
   parameter int SYNC   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              rxd,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_frame_err,
   output logic              rx_parity_err
);

   localparam int TCW = $clog2(OVS);
   localparam int BW  = $clog2(DATA_W + 1);
   localparam logic [TCW-1:0] HALF_LAST = TCW'(OVS/2 - 1);
   localparam logic [TCW-1:0] CELL_LAST = TCW'(OVS - 1);

   // synchronizer chain, one flop per stage
   logic [SYNC-1:0] sync_q;
   genvar gi;
   generate
      for (gi = 0; gi < SYNC; gi++) begin : g_sync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       sync_q[gi] <= 1'b1;
            else if (gi == 0) sync_q[gi] <= rxd;
            else              sync_q[gi] <= sync_q[(gi == 0) ? 0 : gi-1];
         end
      end
   endgenerate

   logic              rx_s;
   logic              rx_prev;
   logic              fall;
   rx_state_e         st;
   logic [TCW-1:0]    tcnt;
   logic [BW-1:0]     bidx;
   logic [DATA_W-1:0] shreg;
   logic              pbit_q;
   logic              pen_q;
   logic              podd_q;

   assign rx_s = sync_q[SYNC-1];
   assign fall = rx_prev & ~rx_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_prev       <= 1'b1;
         st            <= RX_IDLE;
         tcnt          <= '0;
         bidx          <= '0;
         shreg         <= '0;
         pbit_q        <= 1'b0;
         pen_q         <= 1'b0;
         podd_q        <= 1'b0;
         rx_valid      <= 1'b0;
         rx_data       <= '0;
         rx_frame_err  <= 1'b0;
         rx_parity_err <= 1'b0;
      end else begin
         rx_prev  <= rx_s;
         rx_valid <= 1'b0;
         case (st)
            RX_IDLE: begin
               if (fall) begin
                  tcnt   <= '0;
                  pen_q  <= par_en;
                  podd_q <= par_odd;
                  st     <= RX_START;
               end
            end
            RX_START: begin
               if (tick) begin
                  if (tcnt == HALF_LAST) begin
                     tcnt <= '0;
                     bidx <= '0;
                     st   <= rx_s ? RX_IDLE : RX_DATA;
                  end else begin
                     tcnt <= tcnt + TCW'(1);
                  end
               end
            end
            RX_DATA: begin
               if (tick) begin
                  if (tcnt == CELL_LAST) begin
                     tcnt  <= '0;
                     shreg <= {rx_s, shreg[DATA_W-1:1]};
                     bidx  <= bidx + BW'(1);
                     if (bidx == BW'(DATA_W - 1))
                        st <= pen_q ? RX_PAR : RX_STOP;
                  end else begin
                     tcnt <= tcnt + TCW'(1);
                  end
               end
            end
            RX_PAR: begin
               if (tick) begin
                  if (tcnt == CELL_LAST) begin
                     tcnt   <= '0;
                     pbit_q <= rx_s;
                     st     <= RX_STOP;
                  end else begin
                     tcnt <= tcnt + TCW'(1);
                  end
               end
            end
            RX_STOP: begin
               if (tick) begin
                  if (tcnt == CELL_LAST) begin
                     tcnt          <= '0;
                     rx_valid      <= 1'b1;
                     rx_data       <= shreg;
                     rx_frame_err  <= ~rx_s;
                     rx_parity_err <= pen_q & (((^shreg) ^ pbit_q) != podd_q);
                     st            <= RX_IDLE;
                  end else begin
                     tcnt <= tcnt + TCW'(1);
                  end
               end
            end
            default: st <= RX_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/serial_xcvr.sv
`timescale 1ns/1ps
module serial_xcvr #(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int DIV_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  baud_div,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic [1:0]        stop_sel,
   input  logic              tx_valid,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_busy,
   output logic              txd,
   input  logic              rxd,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_frame_err,
   output logic              rx_parity_err
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("serial_xcvr: DATA_W must be at least 2");
      end
      if ((OVS < 4) || ((OVS % 2) != 0)) begin : g_bad_ovs
         $error("serial_xcvr: OVS must be even and at least 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("serial_xcvr: SYNC_STAGES must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("serial_xcvr: DIV_W must be at least 1");
      end
   endgenerate

   logic tick;

   serial_xcvr_baud #(.DIV_W(DIV_W)) u_baud (
      .clk      (clk),
      .rst_n    (rst_n),
      .baud_div (baud_div),
      .tick     (tick)
   );

   serial_xcvr_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .par_en   (par_en),
      .par_odd  (par_odd),
      .stop_sel (stop_sel),
      .tx_valid (tx_valid),
      .tx_data  (tx_data),
      .tx_busy  (tx_busy),
      .txd      (txd)
   );

   serial_xcvr_rx #(.DATA_W(DATA_W), .OVS(OVS), .SYNC(SYNC_STAGES)) u_rx (
      .clk           (clk),
      .rst_n         (rst_n),
      .tick          (tick),
      .par_en        (par_en),
      .par_odd       (par_odd),
      .rxd           (rxd),
      .rx_valid      (rx_valid),
      .rx_data       (rx_data),
      .rx_frame_err  (rx_frame_err),
      .rx_parity_err (rx_parity_err)
   );

endmodule

// File: rtl/serial_xcvr_chk.sv
`timescale 1ns/1ps
module serial_xcvr_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_valid,
   input logic              tx_busy,
   input logic              txd,
   input logic              rx_valid,
   input logic [DATA_W-1:0] rx_data,
   input logic              rx_frame_err,
   input logic              rx_parity_err
);

   p_idle_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> txd);

   p_start_on_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_busy) |=> (tx_busy && !txd));

   p_busy_needs_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_busy) |-> $past(tx_valid));

   p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> ($stable(rx_data) && $stable(rx_frame_err) && $stable(rx_parity_err)));

endmodule

bind serial_xcvr serial_xcvr_chk #(.DATA_W(DATA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .tx_valid      (tx_valid),
   .tx_busy       (tx_busy),
   .txd           (txd),
   .rx_valid      (rx_valid),
   .rx_data       (rx_data),
   .rx_frame_err  (rx_frame_err),
   .rx_parity_err (rx_parity_err)
);

// File: tb/test_serial_xcvr.sv
`timescale 1ns/1ps
module test_serial_xcvr;

   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [15:0]   baud_div = 16'd2;
   logic          par_en = 1'b0;
   logic          par_odd = 1'b0;
   logic [1:0]    stop_sel = 2'd0;
   logic          tx_valid = 1'b0;
   logic [DW-1:0] tx_data = '0;
   logic          tx_busy;
   logic          txd;
   logic          loop = 1'b1;
   logic          drv_rxd = 1'b1;
   logic          rxd;
   logic          rx_valid;
   logic [DW-1:0] rx_data;
   logic          rx_frame_err;
   logic          rx_parity_err;

   int n_chk = 0;
   int n_fail = 0;
   int n_rx = 0;
   int busy_cnt = 0;
   int last_busy = 0;
   logic [DW+1:0] exp_q[$];
   logic [DW+1:0] mon_e;

   always #2.5 clk = ~clk;

   assign rxd = loop ? txd : drv_rxd;

   serial_xcvr i_serial_xcvr (
      .clk           (clk),
      .rst_n         (rst_n),
      .baud_div      (baud_div),
      .par_en        (par_en),
      .par_odd       (par_odd),
      .stop_sel      (stop_sel),
      .tx_valid      (tx_valid),
      .tx_data       (tx_data),
      .tx_busy       (tx_busy),
      .txd           (txd),
      .rxd           (rxd),
      .rx_valid      (rx_valid),
      .rx_data       (rx_data),
      .rx_frame_err  (rx_frame_err),
      .rx_parity_err (rx_parity_err)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic int cell_cycles();
      return 16 * ((baud_div == 16'd0) ? 1 : int'(baud_div));
   endfunction

   // monitor: pops the scoreboard on every received byte
   always @(negedge clk) begin
      if (rst_n && rx_valid) begin
         n_rx++;
         if (exp_q.size() == 0) begin
            chk(1'b0, "R7", "unexpected received byte", 32'(rx_data), 32'h0);
         end else begin
            mon_e = exp_q.pop_front();
            chk(rx_data == mon_e[DW-1:0], "R7", "received byte", 32'(rx_data), 32'(mon_e[DW-1:0]));
            chk(rx_frame_err == mon_e[DW], "R9", "framing flag", 32'(rx_frame_err), 32'(mon_e[DW]));
            chk(rx_parity_err == mon_e[DW+1], "R8", "parity flag", 32'(rx_parity_err), 32'(mon_e[DW+1]));
         end
      end
   end

   // busy length meter
   always @(negedge clk) begin
      if (tx_busy) busy_cnt++;
      else if (busy_cnt != 0) begin
         last_busy = busy_cnt;
         busy_cnt  = 0;
      end
   end

   // send one byte, decode txd at cell centres, check busy length
   task automatic tx_frame(input logic [DW-1:0] d, input bit poke);
      int bitc;
      int div;
      int tks;
      logic [DW-1:0] got;
      logic st0, pb, sb;
      bitc = cell_cycles();
      div  = bitc / 16;
      got  = '0;
      pb   = 1'b0;
      @(negedge clk);
      tx_valid = 1'b1;
      tx_data  = d;
      if (loop) exp_q.push_back({1'b0, 1'b0, d});
      @(negedge clk);
      tx_valid = 1'b0;
      repeat (bitc/2 - 1) @(negedge clk);
      st0 = txd;
      if (poke) begin
         tx_valid = 1'b1;      // R3: request while busy must be ignored
         tx_data  = ~d;
         @(negedge clk);
         tx_valid = 1'b0;
         repeat (bitc - 1) @(negedge clk);
      end else begin
         repeat (bitc) @(negedge clk);
      end
      for (int i = 0; i < DW; i++) begin
         got[i] = txd;
         repeat (bitc) @(negedge clk);
      end
      if (par_en) begin
         pb = txd;
         repeat (bitc) @(negedge clk);
      end
      sb = txd;
      while (tx_busy) @(negedge clk);
      @(negedge clk);
      chk(st0 == 1'b0, "R3", "start bit", 32'(st0), 32'h0);
      chk(got == d, "R3", "serialized data", 32'(got), 32'(d));
      if (par_en)
         chk(pb == ((^d) ^ par_odd), "R4", "parity bit", 32'(pb), 32'((^d) ^ par_odd));
      chk(sb == 1'b1, "R5", "stop level", 32'(sb), 32'h1);
      tks = 16 * (9 + int'(par_en)) + ((stop_sel == 2'd0) ? 16 : (stop_sel == 2'd1) ? 24 : 32);
      chk((last_busy >= tks*div - div - 1) && (last_busy <= tks*div + div + 1),
          "R5", "busy length (R2 tick period)", 32'(last_busy), 32'(tks*div));
   endtask

   // drive a frame on rxd directly
   task automatic rx_frame(input logic [DW-1:0] d, input bit flip, input logic stopv);
      int bitc;
      bitc = cell_cycles();
      @(negedge clk);
      exp_q.push_back({flip & par_en, ~stopv, d});
      drv_rxd = 1'b0;
      repeat (bitc) @(negedge clk);
      for (int i = 0; i < DW; i++) begin
         drv_rxd = d[i];
         repeat (bitc) @(negedge clk);
      end
      if (par_en) begin
         drv_rxd = (^d) ^ par_odd ^ flip;
         repeat (bitc) @(negedge clk);
      end
      drv_rxd = stopv;
      repeat (bitc) @(negedge clk);
      drv_rxd = 1'b1;
   endtask

   task automatic drain(input string req);
      repeat (2 * cell_cycles()) @(negedge clk);
      chk(exp_q.size() == 0, req, "scoreboard drained", 32'(exp_q.size()), 32'h0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      int rx0;
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(txd == 1'b1, "R1", "txd after reset", 32'(txd), 32'h1);
      chk(tx_busy == 1'b0, "R1", "busy after reset", 32'(tx_busy), 32'h0);
      chk(rx_valid == 1'b0, "R1", "rx_valid after reset", 32'(rx_valid), 32'h0);

      // loopback, no parity, one stop; two frames back to back (R10)
      tx_frame(8'hA5, 1'b0);
      tx_frame(8'h3C, 1'b0);
      drain("R10");

      // parity senses (R4) and stop lengths (R5)
      par_en = 1'b1; par_odd = 1'b0;
      tx_frame(8'h01, 1'b0);
      par_odd = 1'b1;
      tx_frame(8'hF0, 1'b0);
      stop_sel = 2'd1;
      tx_frame(8'h5A, 1'b0);
      stop_sel = 2'd2;
      tx_frame(8'hC3, 1'b0);
      stop_sel = 2'd3;
      tx_frame(8'h7E, 1'b0);
      drain("R4");

      // request during busy is dropped (R3)
      par_en = 1'b0; stop_sel = 2'd0;
      tx_frame(8'h96, 1'b1);
      drain("R3");

      // other divider values (R2)
      baud_div = 16'd3;
      tx_frame(8'h81, 1'b0);
      baud_div = 16'd0;
      tx_frame(8'h42, 1'b0);
      drain("R2");
      baud_div = 16'd2;

      // direct receive: good, bad parity, bad stop
      loop = 1'b0;
      par_en = 1'b1; par_odd = 1'b0;
      rx_frame(8'h6D, 1'b0, 1'b1);
      rx_frame(8'h6D, 1'b1, 1'b1);   // R8
      par_odd = 1'b1;
      rx_frame(8'hB2, 1'b1, 1'b1);   // R8 odd sense
      rx_frame(8'h12, 1'b0, 1'b0);   // R9
      par_en = 1'b0;
      rx_frame(8'hEE, 1'b1, 1'b1);   // R8: no flag without parity
      rx_frame(8'h0F, 1'b0, 1'b1);   // R10 with no gap after stop
      rx_frame(8'hF1, 1'b0, 1'b1);
      drain("R9");

      // false start shorter than half a cell (R6)
      rx0 = n_rx;
      @(negedge clk);
      drv_rxd = 1'b0;
      repeat (cell_cycles() / 4) @(negedge clk);
      drv_rxd = 1'b1;
      repeat (3 * cell_cycles()) @(negedge clk);
      chk(n_rx == rx0, "R6", "bytes after glitch", 32'(n_rx - rx0), 32'h0);
      rx_frame(8'h55, 1'b0, 1'b1);
      drain("R6");

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule